// File: doc/BRIEF.md
# Decode Next-Address Checker

This stage sits between fetch and the later pipeline stages. Each incoming packet carries an instruction's address, the next address that fetch guessed, and two epoch tags: one owned by execute and one owned by decode. A pre-decoder supplies the branch class and any target that is known statically. The stage first uses its stored epochs to decide whether the packet still belongs to the live path. Stale packets are thrown away. Live packets have their guessed next address compared with what decode can work out.

When decode finds that fetch guessed wrong, it moves the packet into a new decode epoch. It replaces the guess with its own corrected address and sends a redirect toward fetch on a separate feedback port. A change of exec epoch always resynchronises decode, whatever decode epoch the packet carries. The live packet goes downstream on the forward port with its corrected fields. Both outputs use valid/ready handshakes. A packet is taken only when every port it needs is ready.

Top module: `dec_nap_check`

## Requirements
- R1: After reset both stored epochs are 0, so a packet tagged exec 0 / decode 0 is live and one tagged exec 0 / decode 1 is stale.
- R2: A packet is live when its exec epoch differs from the stored exec epoch, or when its decode epoch equals the stored decode epoch; otherwise it is stale.
- R3: Branch class encoding is 0 = plain, 1 = conditional, 2 = direct jump, 3 = indirect jump. The decoded address is pc+4 for class 0, the static target for classes 1 and 2, and the guessed address for class 3.
- R4: A live packet is mispredicted when the decoded address differs from the guess, and a class 1 packet is also mispredicted when pc+4 differs from the guess.
- R5: On a mispredict the forwarded decode epoch is the packet's decode epoch plus one, wrapping modulo 4, and the forwarded next address is the decoded address.
- R6: On a mispredict the feedback port carries the packet's exec epoch, the new decode epoch, the predictor info and the decoded address.
- R7: A stale packet produces neither a forward nor a feedback transfer, is consumed at once, and leaves the stored epochs unchanged.
- R8: When a live packet is consumed, the stored exec and decode epochs take the forwarded packet's exec and decode epochs.
- R9: A live packet is consumed only when the forward port is ready and, if it mispredicts, the feedback port is also ready. Each output's valid is raised only in a cycle in which the packet is consumed.
- R10: A live, correctly guessed packet is forwarded with its guess, epochs, class and info unchanged, and no feedback is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Incoming packet taken this cycle when valid |
| in_pc | input | ADDR_W | Instruction address |
| in_pred | input | ADDR_W | Next address guessed by fetch |
| in_xep | input | EP_W | Exec epoch tag |
| in_dep | input | EP_W | Decode epoch tag |
| in_cls | input | 2 | Branch class |
| in_tgt | input | ADDR_W | Statically known target |
| in_info | input | INFO_W | Predictor training info |
| fw_valid | output | 1 | Forward packet valid |
| fw_ready | input | 1 | Downstream can accept |
| fw_pc | output | ADDR_W | Instruction address |
| fw_pred | output | ADDR_W | Next address, corrected if needed |
| fw_xep | output | EP_W | Exec epoch tag |
| fw_dep | output | EP_W | Decode epoch tag, advanced on mispredict |
| fw_cls | output | 2 | Branch class |
| fw_info | output | INFO_W | Predictor info |
| fb_valid | output | 1 | Redirect valid |
| fb_ready | input | 1 | Fetch can accept a redirect |
| fb_xep | output | EP_W | Exec epoch of the redirect |
| fb_dep | output | EP_W | New decode epoch |
| fb_info | output | INFO_W | Predictor info |
| fb_addr | output | ADDR_W | Redirect address |

## Verification
Directed packets cover each branch class with a matching guess and with a wrong guess. A conditional branch is tried whose guess equals the target but not pc+4, which separates the extra conditional rule from the plain comparison. Stale packets that follow a redirect show that the epoch filter drops them and leaves the stored state alone. A packet with a fresh exec epoch and an old decode epoch shows the resynchronisation, and a redirect from decode epoch 3 shows the wrap to 0. Back-pressure on each port separately, together with a long random mix, shows that a packet is consumed only when both ports are free.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [1:0] {
    BC_PLAIN    = 2'd0,
    BC_COND     = 2'd1,
    BC_JUMP     = 2'd2,
    BC_INDIRECT = 2'd3
  } br_cls_e;
endpackage

// File: rtl/nap_path_filter.sv
module nap_path_filter #(
  parameter int EP_W = 2
) (
  input  logic [EP_W-1:0] pkt_xep,
  input  logic [EP_W-1:0] pkt_dep,
  input  logic [EP_W-1:0] st_xep,
  input  logic [EP_W-1:0] st_dep,
  output logic            live
);
  logic new_exec;
  logic same_dec;

  always_comb begin
    new_exec = (pkt_xep != st_xep);
    same_dec = (pkt_dep == st_dep);
    live     = new_exec | same_dec;
  end
endmodule

// File: rtl/nap_target_eval.sv
module nap_target_eval
  import nap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] guess,
  input  logic [1:0]        cls,
  input  logic [ADDR_W-1:0] static_tgt,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              wrong
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] seq_addr;
  logic              cond_seq_miss;

  always_comb begin
    seq_addr = pc + STEP;
    unique case (br_cls_e'(cls))
      BC_PLAIN:             dec_addr = seq_addr;
      BC_COND, BC_JUMP:     dec_addr = static_tgt;
      default:              dec_addr = guess;
    endcase
    cond_seq_miss = (br_cls_e'(cls) == BC_COND) && (seq_addr != guess);
    wrong         = (dec_addr != guess) || cond_seq_miss;
  end
endmodule

// File: rtl/nap_epoch_regs.sv
module nap_epoch_regs #(
  parameter int EP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [EP_W-1:0] upd_xep,
  input  logic [EP_W-1:0] upd_dep,
  output logic [EP_W-1:0] st_xep,
  output logic [EP_W-1:0] st_dep
);
  logic [EP_W-1:0] xep_nx;
  logic [EP_W-1:0] dep_nx;

  always_comb begin
    xep_nx = st_xep;
    dep_nx = st_dep;
    if (upd_en) begin
      xep_nx = upd_xep;
      dep_nx = upd_dep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_xep <= '0;
      st_dep <= '0;
    end else begin
      st_xep <= xep_nx;
      st_dep <= dep_nx;
    end
  end
endmodule

// File: rtl/dec_nap_check.sv
module dec_nap_check #(
  parameter int ADDR_W     = 32,
  parameter int EP_W       = 2,
  parameter int INFO_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_pred,
  input  logic [EP_W-1:0]   in_xep,
  input  logic [EP_W-1:0]   in_dep,
  input  logic [1:0]        in_cls,
  input  logic [ADDR_W-1:0] in_tgt,
  input  logic [INFO_W-1:0] in_info,
  output logic              fw_valid,
  input  logic              fw_ready,
  output logic [ADDR_W-1:0] fw_pc,
  output logic [ADDR_W-1:0] fw_pred,
  output logic [EP_W-1:0]   fw_xep,
  output logic [EP_W-1:0]   fw_dep,
  output logic [1:0]        fw_cls,
  output logic [INFO_W-1:0] fw_info,
  output logic              fb_valid,
  input  logic              fb_ready,
  output logic [EP_W-1:0]   fb_xep,
  output logic [EP_W-1:0]   fb_dep,
  output logic [INFO_W-1:0] fb_info,
  output logic [ADDR_W-1:0] fb_addr
);
  localparam logic [EP_W-1:0] EP_ONE = EP_W'(1);

  logic [EP_W-1:0]   st_xep;
  logic [EP_W-1:0]   st_dep;
  logic              live;
  logic              wrong;
  logic [ADDR_W-1:0] dec_addr;
  logic [EP_W-1:0]   fin_xep;
  logic [EP_W-1:0]   fin_dep;
  logic              outs_free;
  logic              take;

  nap_path_filter #(.EP_W(EP_W)) u_filter (
    .pkt_xep (in_xep),
    .pkt_dep (in_dep),
    .st_xep  (st_xep),
    .st_dep  (st_dep),
    .live    (live)
  );

  nap_target_eval #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_eval (
    .pc         (in_pc),
    .guess      (in_pred),
    .cls        (in_cls),
    .static_tgt (in_tgt),
    .dec_addr   (dec_addr),
    .wrong      (wrong)
  );

  always_comb begin
    outs_free = fw_ready && (!wrong || fb_ready);
    in_ready  = !live || outs_free;
    take      = in_valid && in_ready;

    if (live) begin
      fin_xep = in_xep;
      fin_dep = wrong ? (in_dep + EP_ONE) : in_dep;
    end else begin
      fin_xep = st_xep;
      fin_dep = st_dep;
    end

    fw_valid = in_valid && live && outs_free;
    fw_pc    = in_pc;
    fw_pred  = wrong ? dec_addr : in_pred;
    fw_xep   = fin_xep;
    fw_dep   = fin_dep;
    fw_cls   = in_cls;
    fw_info  = in_info;

    fb_valid = in_valid && live && wrong && outs_free;
    fb_xep   = in_xep;
    fb_dep   = fin_dep;
    fb_info  = in_info;
    fb_addr  = dec_addr;
  end

  nap_epoch_regs #(.EP_W(EP_W)) u_epochs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (take),
    .upd_xep (fin_xep),
    .upd_dep (fin_dep),
    .st_xep  (st_xep),
    .st_dep  (st_dep)
  );
endmodule

// File: rtl/dec_nap_check_sva.sv
module dec_nap_check_sva #(
  parameter int ADDR_W = 32,
  parameter int EP_W   = 2,
  parameter int INFO_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_pred,
  input logic [EP_W-1:0]   in_xep,
  input logic [EP_W-1:0]   in_dep,
  input logic              fw_valid,
  input logic              fw_ready,
  input logic [ADDR_W-1:0] fw_pred,
  input logic [EP_W-1:0]   fw_xep,
  input logic [EP_W-1:0]   fw_dep,
  input logic              fb_valid,
  input logic              fb_ready,
  input logic [EP_W-1:0]   fb_xep,
  input logic [EP_W-1:0]   fb_dep,
  input logic [ADDR_W-1:0] fb_addr,
  input logic [EP_W-1:0]   st_xep,
  input logic [EP_W-1:0]   st_dep
);
  logic stale_in;
  assign stale_in = in_valid && (in_xep == st_xep) && (in_dep != st_dep);

  // R7: stale packets reach neither output
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stale_in |-> (!fw_valid && !fb_valid && in_ready));

  // R7: stale packets leave the stored epochs as they were
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stale_in |=> ($stable(st_xep) && $stable(st_dep)));

  // R9: no consumption means no change of state
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(st_xep) && $stable(st_dep)));

  // R9: a redirect only leaves together with its forward packet
  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> (fw_valid && fw_ready && fb_ready));

  // R6: redirect matches the forwarded packet
  p_fbmatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> (fb_dep == fw_dep && fb_addr == fw_pred && fb_xep == fw_xep));

  // R5: new decode epoch is one past the incoming one
  p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> (fb_dep == EP_W'(in_dep + EP_W'(1))));

  // R8: stored epochs follow the forwarded packet
  p_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |=> (st_xep == $past(fw_xep) && st_dep == $past(fw_dep)));

  // R10: a packet forwarded untouched sends no redirect
  p_nofb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_pred == in_pred && fw_dep == in_dep) |-> !fb_valid);
endmodule

bind dec_nap_check dec_nap_check_sva #(
  .ADDR_W(ADDR_W), .EP_W(EP_W), .INFO_W(INFO_W)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_pred  (in_pred),
  .in_xep   (in_xep),
  .in_dep   (in_dep),
  .fw_valid (fw_valid),
  .fw_ready (fw_ready),
  .fw_pred  (fw_pred),
  .fw_xep   (fw_xep),
  .fw_dep   (fw_dep),
  .fb_valid (fb_valid),
  .fb_ready (fb_ready),
  .fb_xep   (fb_xep),
  .fb_dep   (fb_dep),
  .fb_addr  (fb_addr),
  .st_xep   (st_xep),
  .st_dep   (st_dep)
);

// File: tb/tb_dec_nap_check.sv
module tb_dec_nap_check;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_pc, in_pred, in_tgt, in_info;
  logic [1:0]  in_xep, in_dep, in_cls;
  logic        fw_valid, fw_ready;
  logic [31:0] fw_pc, fw_pred, fw_info;
  logic [1:0]  fw_xep, fw_dep, fw_cls;
  logic        fb_valid, fb_ready;
  logic [1:0]  fb_xep, fb_dep;
  logic [31:0] fb_info, fb_addr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // reference state
  logic [1:0] m_x = 2'd0;
  logic [1:0] m_d = 2'd0;

  dec_nap_check dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_pred(in_pred), .in_xep(in_xep), .in_dep(in_dep),
    .in_cls(in_cls), .in_tgt(in_tgt), .in_info(in_info),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_pc(fw_pc), .fw_pred(fw_pred),
    .fw_xep(fw_xep), .fw_dep(fw_dep), .fw_cls(fw_cls), .fw_info(fw_info),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_xep(fb_xep), .fb_dep(fb_dep),
    .fb_info(fb_info), .fb_addr(fb_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, then advance model at the edge
  task automatic step(input string tag, input logic v, input logic [31:0] pc,
                      input logic [31:0] pred, input logic [1:0] xe, input logic [1:0] de,
                      input logic [1:0] cls, input logic [31:0] tgt, input logic [31:0] info,
                      input logic fwr, input logic fbr);
    logic        e_live, e_wrong, e_rdy, e_fw, e_fb;
    logic [31:0] e_addr;
    logic [1:0]  e_dep;
    @(negedge clk);
    in_valid = v; in_pc = pc; in_pred = pred; in_xep = xe; in_dep = de;
    in_cls = cls; in_tgt = tgt; in_info = info; fw_ready = fwr; fb_ready = fbr;
    #1;
    e_live = (xe != m_x) || (de == m_d);
    case (cls)
      2'd0:    e_addr = pc + 32'd4;
      2'd1,
      2'd2:    e_addr = tgt;
      default: e_addr = pred;
    endcase
    e_wrong = (e_addr != pred) || (cls == 2'd1 && (pc + 32'd4) != pred);
    e_dep   = e_wrong ? de + 2'd1 : de;
    e_rdy   = !e_live || (fwr && (!e_wrong || fbr));
    e_fw    = v && e_live && e_rdy;
    e_fb    = e_fw && e_wrong;
    chk({tag, " R9 in_ready"}, 32'(in_ready), 32'(e_rdy));
    chk({tag, " R7/R9 fw_valid"}, 32'(fw_valid), 32'(e_fw));
    chk({tag, " R7/R9 fb_valid"}, 32'(fb_valid), 32'(e_fb));
    if (e_fw) begin
      chk({tag, " R10 fw_pc"}, fw_pc, pc);
      chk({tag, " R5 fw_pred"}, fw_pred, e_wrong ? e_addr : pred);
      chk({tag, " R5 fw_dep"}, 32'(fw_dep), 32'(e_dep));
      chk({tag, " R10 fw_xep"}, 32'(fw_xep), 32'(xe));
      chk({tag, " R10 fw_cls"}, 32'(fw_cls), 32'(cls));
      chk({tag, " R10 fw_info"}, fw_info, info);
    end
    if (e_fb) begin
      chk({tag, " R6 fb_xep"}, 32'(fb_xep), 32'(xe));
      chk({tag, " R6 fb_dep"}, 32'(fb_dep), 32'(e_dep));
      chk({tag, " R6 fb_info"}, fb_info, info);
      chk({tag, " R3 fb_addr"}, fb_addr, e_addr);
    end
    @(posedge clk);
    if (v && e_rdy && e_live) begin
      m_x = xe;
      m_d = e_dep;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_pc = 0; in_pred = 0; in_xep = 0; in_dep = 0;
    in_cls = 0; in_tgt = 0; in_info = 0; fw_ready = 1; fb_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset epochs are 0 -> (0,1) is stale, (0,0) is live
    step("R1 stale", 1, 32'h100, 32'h104, 2'd0, 2'd1, 2'd0, 0, 32'h11, 1, 1);
    step("R1 live",  1, 32'h100, 32'h104, 2'd0, 2'd0, 2'd0, 0, 32'h12, 1, 1);
    // R10 / R3 class 0 good guess
    step("R10 plain ok", 1, 32'h104, 32'h108, m_x, m_d, 2'd0, 32'h0, 32'h13, 1, 1);
    // R4 class 0 wrong guess
    step("R4 plain bad", 1, 32'h108, 32'h200, m_x, m_d, 2'd0, 32'h0, 32'h14, 1, 1);
    // R7 stale packet with old decode epoch after redirect
    step("R7 old dep", 1, 32'h200, 32'h204, m_x, m_d - 2'd1, 2'd0, 0, 32'h15, 1, 1);
    // R4 cond: guess = pc+4, target differs -> redirect to target
    step("R4 cond seq", 1, 32'h10c, 32'h110, m_x, m_d, 2'd1, 32'h300, 32'h16, 1, 1);
    // R4 cond: guess = target but not pc+4 -> still flagged
    step("R4 cond tgt", 1, 32'h300, 32'h400, m_x, m_d, 2'd1, 32'h400, 32'h17, 1, 1);
    // R3 direct jump, correct and wrong
    step("R3 jump ok",  1, 32'h400, 32'h500, m_x, m_d, 2'd2, 32'h500, 32'h18, 1, 1);
    step("R3 jump bad", 1, 32'h500, 32'h504, m_x, m_d, 2'd2, 32'h600, 32'h19, 1, 1);
    // R3 indirect keeps guess
    step("R3 indirect", 1, 32'h600, 32'h9990, m_x, m_d, 2'd3, 32'h700, 32'h1a, 1, 1);
    // R2 new exec epoch with stale decode epoch is live
    step("R2 new exec", 1, 32'h800, 32'h804, m_x + 2'd1, m_d + 2'd2, 2'd0, 0, 32'h1b, 1, 1);
    // R9 back-pressure: forward not ready, then feedback not ready on mispredict
    step("R9 fw stall", 1, 32'h804, 32'h808, m_x, m_d, 2'd0, 0, 32'h1c, 0, 1);
    step("R9 fb stall", 1, 32'h804, 32'h900, m_x, m_d, 2'd0, 0, 32'h1d, 1, 0);
    step("R9 fb ok",    1, 32'h804, 32'h808, m_x, m_d, 2'd0, 0, 32'h1e, 1, 0);
    // R7 stale packet under back-pressure is still consumed
    step("R7 stale bp", 1, 32'h900, 32'h904, m_x, m_d + 2'd1, 2'd0, 0, 32'h1f, 0, 0);
    // R5 wrap: walk decode epoch to 3 then mispredict
    while (m_d != 2'd3)
      step("R5 walk", 1, 32'h40, 32'h80, m_x, m_d, 2'd0, 0, 32'h20, 1, 1);
    step("R5 wrap", 1, 32'h40, 32'h80, m_x, m_d, 2'd0, 0, 32'h21, 1, 1);
    // R8 idle cycle then live packet using model epochs
    step("R8 idle", 0, 32'h0, 32'h0, m_x, m_d, 2'd0, 0, 32'h0, 1, 1);
    step("R8 follow", 1, 32'h80, 32'h84, m_x, m_d, 2'd0, 0, 32'h22, 1, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r, pc, pred, tgt;
      logic [1:0]  xe, de;
      r  = $urandom;
      pc = {$urandom % 32'h400, 2'b00};
      tgt = r[3] ? pc + 32'd4 : {$urandom % 32'h400, 2'b00};
      case (r[5:4])
        2'd0: pred = pc + 32'd4;
        2'd1: pred = tgt;
        default: pred = {$urandom % 32'h400, 2'b00};
      endcase
      xe = (r[9:6] == 0) ? m_x + 2'd1 : m_x;
      de = (r[12:10] == 0) ? r[14:13] : m_d;
      step("R2/R4 rand", r[15] | r[16], pc, pred, xe, de, r[18:17], tgt,
           $urandom, r[19] | r[20], r[21] | r[22]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule